// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Indexed Pin Configuration

This block controls 29 general-purpose pins, grouped into 8-bit ports. The host uses one byte-wide register bus. A low window gives each port a data-out register and a data-in register. The first two ports also have an edge-event enable register and an edge-event status register. Each pin's electrical setup is reached indirectly. The host first writes a pin-select register to name one pin by port and bit. A pin-config register then reads or writes that pin's output enable, drive type and pull-up bits.

The outputs go to the pad ring. For every pin there is a drive value, an output enable and a pull-up request. Open-drain operation is produced by switching the output enable and driving the value low. Pad inputs are brought in through a two-flop synchronizer. Interrupt routing beyond the status bits is outside this block.

Top module: `gpio_multiport`

## Requirements
- R1: After a synchronous active-low reset, all data-out bits, output enables, push-pull bits, pull-ups, event enables, event status bits and the pin selection are 0, so every pad is undriven with its pull-up off.
- R2: The data-out registers of ports 0, 1, 2 and 3 are at addresses 0x00, 0x04, 0x08 and 0x0A. They are read/write, and port 3 bits 7:5 (no pin) read as 0.
- R3: The data-in registers of ports 0 to 3 are at 0x01, 0x05, 0x09 and 0x0B. They return the pad levels of pins port*8+bit after two clock edges of synchronization. Bits above pin 28 read as 0.
- R4: The pin-select register at address 0xF0 takes (port << 4) | bit, with port in bits 5:4 and bit in bits 2:0, and selects pin port*8+bit. It reads back those fields, with bits 7:6 and 3 as 0.
- R5: The pin-config register at 0xF1 reads and writes the selected pin's setup: bit 0 output enable, bit 1 push-pull (0 = open-drain), bit 2 pull-up. Bits 7:3 read 0. If the selected pin is beyond pin 28, the register reads 0 and writes to it change nothing.
- R6: Pad outputs per pin:
  - With output enable 0, pad_oe is 0.
  - With output enable and push-pull both set, pad_oe is 1 and pad_out equals the data-out bit.
  - With output enable set and open-drain selected, pad_oe is the inverse of the data-out bit and pad_out is 0.
  - In every state, pad_out is the data-out bit only when push-pull is set (0 otherwise), and pad_pu equals the pull-up bit.
- R7: The event enable registers for ports 0 and 1 are at 0x02 and 0x06 and are read/write.
- R8: The event status registers are at 0x03 and 0x07. A status bit sets on a 0-to-1 change of that pin's synchronized level while its enable bit is 1. The bit becomes visible one clock after the new level shows in data-in.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it. A new edge in the same cycle as the clear keeps the bit set.
- R10: Reads of any other address return 0, and writes to any other address change no register or pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 29 | Asynchronous pad levels |
| pad_out | output | 29 | Pad drive value |
| pad_oe | output | 29 | Pad output enable |
| pad_pu | output | 29 | Pad pull-up request |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least two clock edges, so the edge detector and the synchronizer start from known zeros.
- The bus fields are stable across each rising edge.

The stimulus keeps within these assumptions. It holds reset for three cycles and changes bus fields and pad levels only on falling edges. Rising pad changes are spaced so that both the edge-to-status delay and the clear-versus-set collision can be placed on a known cycle.

// File: rtl/gpio_mp_pkg.sv
// Package: shared constants, address map helpers and the per-pin config type.
// Assumes at most two ports carry event registers at the low offsets.
package gpio_mp_pkg;

    localparam logic [7:0] SEL_IDX      = 8'hF0;
    localparam logic [7:0] CFG_IDX      = 8'hF1;
    localparam int         SEL_PORT_LSB = 4;

    // Field order matches the pin-config register: bit0 enable, bit1 drive type, bit2 pull-up.
    typedef struct packed {
        logic pull_up;
        logic push_pull;
        logic out_en;
    } pin_cfg_t;

    // Data-out address of port p; ports past the event-capable pair are packed in pairs.
    function automatic logic [7:0] dout_addr(input int p);
        if (p < 2) return 8'(4 * p);
        return 8'(8 + 2 * (p - 2));
    endfunction

    function automatic logic [7:0] din_addr(input int p);
        return dout_addr(p) + 8'd1;
    endfunction

    function automatic logic [7:0] evt_en_addr(input int p);
        return 8'(4 * p + 2);
    endfunction

    function automatic logic [7:0] evt_st_addr(input int p);
        return 8'(4 * p + 3);
    endfunction

endpackage

// File: rtl/gpio_mp_sync.sv
// Module: multi-stage level synchronizer for the asynchronous pad inputs.
// Assumes each input bit is sampled independently (no bus coherence needed).
module gpio_mp_sync #(
    parameter int WIDTH  = 29,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            // R3: output is the input from exactly two edges earlier.
            p_sync_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_mp_pincfg.sv
// Module: pin-select register and per-pin electrical config store.
// Assumes PORT_W is a power of two so that {port, bit} equals the pin number.
module gpio_mp_pincfg
    import gpio_mp_pkg::*;
#(
    parameter int NUM_PINS = 29,
    parameter int PIDX_W   = 2,
    parameter int BIT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_wr,
    input  logic                cfg_wr,
    input  logic [PIDX_W-1:0]   sel_port_in,
    input  logic [BIT_W-1:0]    sel_bit_in,
    input  pin_cfg_t            cfg_in,
    output logic [PIDX_W-1:0]   sel_port,
    output logic [BIT_W-1:0]    sel_bit,
    output pin_cfg_t            cfg_rd,
    output logic [NUM_PINS-1:0] out_en,
    output logic [NUM_PINS-1:0] push_pull,
    output logic [NUM_PINS-1:0] pull_up
);

    localparam int PIN_W = PIDX_W + BIT_W;

    logic [PIDX_W-1:0] sel_port_q;
    logic [BIT_W-1:0]  sel_bit_q;
    logic [PIN_W-1:0]  sel_pin;
    logic              sel_valid;
    pin_cfg_t          cfg_q [NUM_PINS];

    assign sel_pin   = {sel_port_q, sel_bit_q};
    assign sel_valid = (int'(sel_pin) < NUM_PINS);

    // Hold the pin selection written through the select index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_port_q <= '0;
            sel_bit_q  <= '0;
        end else if (sel_wr) begin
            sel_port_q <= sel_port_in;
            sel_bit_q  <= sel_bit_in;
        end
    end

    // Update only the selected pin's config, and only when it exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= '0;
        end else if (cfg_wr && sel_valid) begin
            for (int i = 0; i < NUM_PINS; i++)
                if (int'(sel_pin) == i) cfg_q[i] <= cfg_in;
        end
    end

    // Read back the selected pin's config, zero for a missing pin.
    always_comb begin
        cfg_rd = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (int'(sel_pin) == i) cfg_rd = cfg_q[i];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_fan
            assign out_en[g]    = cfg_q[g].out_en;
            assign push_pull[g] = cfg_q[g].push_pull;
            assign pull_up[g]   = cfg_q[g].pull_up;
        end
    endgenerate

    assign sel_port = sel_port_q;
    assign sel_bit  = sel_bit_q;

    // R5: a config write aimed past the last pin leaves every pin untouched.
    p_cfg_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !sel_valid) |=> ($stable(out_en) && $stable(push_pull) && $stable(pull_up)));

    // R4: the selection moves only on a select write.
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> ($stable(sel_port) && $stable(sel_bit)));

endmodule

// File: rtl/gpio_mp_event.sv
// Module: rising-edge event capture with per-bit enable and write-1-to-clear status.
// Assumes the level input is already synchronized to clk.
module gpio_mp_event #(
    parameter int PORT_W    = 8,
    parameter int EVT_PORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [EVT_PORTS*PORT_W-1:0]   lvl,
    input  logic [EVT_PORTS-1:0]          en_wr,
    input  logic [EVT_PORTS-1:0]          st_wr,
    input  logic [PORT_W-1:0]             wdata,
    output logic [EVT_PORTS*PORT_W-1:0]   en_q,
    output logic [EVT_PORTS*PORT_W-1:0]   st_q
);

    localparam int EVT_PINS = EVT_PORTS * PORT_W;

    logic [EVT_PINS-1:0] prev_q;
    logic [EVT_PINS-1:0] set_v;
    logic [EVT_PINS-1:0] clr_v;
    logic [EVT_PINS-1:0] en_nxt;

    assign set_v = lvl & ~prev_q & en_q;

    genvar p;
    generate
        for (p = 0; p < EVT_PORTS; p++) begin : g_port
            assign clr_v[p*PORT_W +: PORT_W]  = st_wr[p] ? wdata : '0;
            assign en_nxt[p*PORT_W +: PORT_W] = en_wr[p] ? wdata : en_q[p*PORT_W +: PORT_W];
        end
    endgenerate

    // Track previous level, enables and sticky status; a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            en_q   <= '0;
            st_q   <= '0;
        end else begin
            prev_q <= lvl;
            en_q   <= en_nxt;
            st_q   <= (st_q & ~clr_v) | set_v;
        end
    end

    // R8: a status bit only appears where the enable was already set.
    p_set_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

    // R9: a cleared bit with no competing edge is 0 afterwards.
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & $past(clr_v & ~set_v)) == '0));

endmodule

// File: rtl/gpio_multiport.sv
// Module: top of the GPIO controller: register decode, data-out store, read mux, pad drive.
// Assumes one bus access per cycle with fields stable around the clock edge.
module gpio_multiport
    import gpio_mp_pkg::*;
#(
    parameter int NUM_PINS    = 29,
    parameter int PORT_W      = 8,
    parameter int EVT_PORTS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [PORT_W-1:0]   bus_wdata,
    output logic [PORT_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu
);

    localparam int NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;
    localparam int FLAT_W    = NUM_PORTS * PORT_W;
    localparam int EVT_PINS  = EVT_PORTS * PORT_W;
    localparam int PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int BIT_W     = $clog2(PORT_W);

    logic [NUM_PINS-1:0]  dout_q;
    logic [FLAT_W-1:0]    dout_nxt;
    logic [FLAT_W-1:0]    dout_flat;
    logic [NUM_PINS-1:0]  din_q;
    logic [FLAT_W-1:0]    din_flat;
    logic [EVT_PORTS-1:0] en_wr;
    logic [EVT_PORTS-1:0] st_wr;
    logic [EVT_PINS-1:0]  evt_en;
    logic [EVT_PINS-1:0]  evt_st;
    logic [PIDX_W-1:0]    sel_port;
    logic [BIT_W-1:0]     sel_bit;
    pin_cfg_t             cfg_rd;
    logic [NUM_PINS-1:0]  out_en;
    logic [NUM_PINS-1:0]  push_pull;
    logic [NUM_PINS-1:0]  pull_up;
    logic                 sel_wr;
    logic                 cfg_wr;

    assign dout_flat = FLAT_W'(dout_q);
    assign din_flat  = FLAT_W'(din_q);
    assign sel_wr    = bus_wr && (bus_addr == SEL_IDX);
    assign cfg_wr    = bus_wr && (bus_addr == CFG_IDX);

    gpio_mp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (din_q)
    );

    genvar p;
    generate
        for (p = 0; p < EVT_PORTS; p++) begin : g_evt_dec
            assign en_wr[p] = bus_wr && (bus_addr == evt_en_addr(p));
            assign st_wr[p] = bus_wr && (bus_addr == evt_st_addr(p));
        end
    endgenerate

    gpio_mp_event #(.PORT_W(PORT_W), .EVT_PORTS(EVT_PORTS)) u_event (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (din_flat[EVT_PINS-1:0]),
        .en_wr (en_wr),
        .st_wr (st_wr),
        .wdata (bus_wdata),
        .en_q  (evt_en),
        .st_q  (evt_st)
    );

    gpio_mp_pincfg #(.NUM_PINS(NUM_PINS), .PIDX_W(PIDX_W), .BIT_W(BIT_W)) u_pincfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr      (sel_wr),
        .cfg_wr      (cfg_wr),
        .sel_port_in (bus_wdata[SEL_PORT_LSB +: PIDX_W]),
        .sel_bit_in  (bus_wdata[BIT_W-1:0]),
        .cfg_in      (pin_cfg_t'(bus_wdata[2:0])),
        .sel_port    (sel_port),
        .sel_bit     (sel_bit),
        .cfg_rd      (cfg_rd),
        .out_en      (out_en),
        .push_pull   (push_pull),
        .pull_up     (pull_up)
    );

    // Merge a data-out write into the padded port image.
    always_comb begin
        dout_nxt = dout_flat;
        if (bus_wr) begin
            for (int i = 0; i < NUM_PORTS; i++)
                if (bus_addr == dout_addr(i)) dout_nxt[i*PORT_W +: PORT_W] = bus_wdata;
        end
    end

    // Store data-out bits for existing pins only.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_nxt[NUM_PINS-1:0];
    end

    // Select read data by address; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (bus_addr == dout_addr(i)) bus_rdata = dout_flat[i*PORT_W +: PORT_W];
            if (bus_addr == din_addr(i))  bus_rdata = din_flat[i*PORT_W +: PORT_W];
        end
        for (int i = 0; i < EVT_PORTS; i++) begin
            if (bus_addr == evt_en_addr(i)) bus_rdata = evt_en[i*PORT_W +: PORT_W];
            if (bus_addr == evt_st_addr(i)) bus_rdata = evt_st[i*PORT_W +: PORT_W];
        end
        if (bus_addr == SEL_IDX) begin
            bus_rdata[SEL_PORT_LSB +: PIDX_W] = sel_port;
            bus_rdata[BIT_W-1:0]              = sel_bit;
        end
        if (bus_addr == CFG_IDX) bus_rdata = PORT_W'(cfg_rd);
    end

    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pad
            assign pad_oe[p]  = out_en[p] & (push_pull[p] | ~dout_q[p]);
            assign pad_out[p] = push_pull[p] & dout_q[p];
            assign pad_pu[p]  = pull_up[p];
        end
    endgenerate

    // R1: the first cycle out of reset has every pad released with no pull-up.
    p_reset_pads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((pad_oe == '0) && (pad_pu == '0)));

    // R6: an open-drain pin never drives while its data-out bit is high.
    p_od_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~push_pull & dout_q) == '0));

    // R10: a write to an unmapped address leaves the pads unchanged.
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 8'h0C)) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

endmodule

// File: tb/tb_gpio_multiport.sv
// Bench: behavioural reference model updated every clock and compared every cycle,
// plus directed checks for the corner cases of each requirement.
module tb_gpio_multiport;

    localparam int NP = 29;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr;
    logic [7:0]    bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_pu;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;

    always #5 clk = ~clk;

    gpio_multiport dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu)
    );

    // Reference model state
    logic [NP-1:0] m_dout, m_oe, m_pp, m_pu, m_s1, m_s2;
    logic [15:0]   m_prev, m_en, m_st;
    logic [7:0]    m_sel;

    always @(posedge clk) begin
        logic [15:0] clr;
        int pin;
        clr = '0;
        if (!rst_n) begin
            m_dout <= '0; m_oe <= '0; m_pp <= '0; m_pu <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_en <= '0; m_st <= '0; m_sel <= '0;
        end else begin
            m_s1   <= pad_in;
            m_s2   <= m_s1;
            m_prev <= m_s2[15:0];
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_dout[7:0]   <= bus_wdata;
                    8'h04: m_dout[15:8]  <= bus_wdata;
                    8'h08: m_dout[23:16] <= bus_wdata;
                    8'h0A: m_dout[28:24] <= bus_wdata[4:0];
                    8'h02: m_en[7:0]     <= bus_wdata;
                    8'h06: m_en[15:8]    <= bus_wdata;
                    8'h03: clr[7:0]       = bus_wdata;
                    8'h07: clr[15:8]      = bus_wdata;
                    8'hF0: m_sel         <= bus_wdata & 8'h37;
                    8'hF1: begin
                        pin = int'(m_sel[5:4]) * 8 + int'(m_sel[2:0]);
                        if (pin < NP) begin
                            m_oe[pin] <= bus_wdata[0];
                            m_pp[pin] <= bus_wdata[1];
                            m_pu[pin] <= bus_wdata[2];
                        end
                    end
                    default: ;
                endcase
            end
            m_st <= (m_st & ~clr) | (m_s2[15:0] & ~m_prev & m_en);
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        int pin;
        case (a)
            8'h00: return m_dout[7:0];
            8'h01: return m_s2[7:0];
            8'h02: return m_en[7:0];
            8'h03: return m_st[7:0];
            8'h04: return m_dout[15:8];
            8'h05: return m_s2[15:8];
            8'h06: return m_en[15:8];
            8'h07: return m_st[15:8];
            8'h08: return m_dout[23:16];
            8'h09: return m_s2[23:16];
            8'h0A: return {3'b000, m_dout[28:24]};
            8'h0B: return {3'b000, m_s2[28:24]};
            8'hF0: return m_sel;
            8'hF1: begin
                pin = int'(m_sel[5:4]) * 8 + int'(m_sel[2:0]);
                if (pin < NP) return {5'b0, m_pu[pin], m_pp[pin], m_oe[pin]};
                return 8'h00;
            end
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h08, 8'h0A: return "R2";
            8'h01, 8'h05, 8'h09, 8'h0B: return "R3";
            8'h02, 8'h06:               return "R7";
            8'h03, 8'h07:               return "R8/R9";
            8'hF0:                      return "R4";
            8'hF1:                      return "R5";
            default:                    return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of read data and pads against the model
    always begin
        logic [NP-1:0] e_oe, e_out;
        @(negedge clk);
        #4;
        if (cmp_en) begin
            e_oe  = m_oe & (m_pp | ~m_dout);
            e_out = m_pp & m_dout;
            chk(bus_rdata == exp_rd(bus_addr), rst_n ? tag_of(bus_addr) : "R1",
                32'(bus_rdata), 32'(exp_rd(bus_addr)));
            chk((pad_oe == e_oe) && (pad_out == e_out) && (pad_pu == m_pu), rst_n ? "R6" : "R1",
                32'(pad_oe), 32'(e_oe));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #4;
        chk(bus_rdata == e, tag, 32'(bus_rdata), 32'(e));
    endtask

    task automatic settle();
        @(negedge clk);
        #4;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    localparam logic [7:0] ADDRS [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                                          8'h08, 8'h09, 8'h0A, 8'h0B, 8'hF0, 8'hF1, 8'h0C, 8'hF2};

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL all requirements: watchdog expired, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; pad_in = '0;
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        // R1: reset state
        rd_chk(8'h00, 8'h00, "R1");
        chk((pad_oe == '0) && (pad_pu == '0), "R1", 32'(pad_oe), 32'h0);
        rd_chk(8'hF0, 8'h00, "R1");
        @(negedge clk) rst_n = 1'b1;

        // R2: data-out storage, port 3 upper bits absent
        wr(8'h00, 8'hA5); wr(8'h04, 8'h3C); wr(8'h08, 8'hFF); wr(8'h0A, 8'hFF);
        rd_chk(8'h0A, 8'h1F, "R2");
        rd_chk(8'h00, 8'hA5, "R2");
        rd_chk(8'h08, 8'hFF, "R2");

        // R3: two-edge synchronizer latency and missing upper bits
        @(negedge clk) pad_in = '1;
        rd_chk(8'h01, 8'h00, "R3");
        rd_chk(8'h01, 8'hFF, "R3");
        rd_chk(8'h0B, 8'h1F, "R3");
        @(negedge clk) pad_in = '0;
        repeat (3) @(negedge clk);

        // R4: select field readback
        wr(8'hF0, 8'hFF);
        rd_chk(8'hF0, 8'h37, "R4");

        // R5: pin 29 does not exist; pin 28 does
        wr(8'hF0, 8'h35); wr(8'hF1, 8'h07);
        rd_chk(8'hF1, 8'h00, "R5");
        chk(pad_pu == '0, "R5", 32'(pad_pu), 32'h0);
        wr(8'hF0, 8'h34); wr(8'hF1, 8'hFF);
        rd_chk(8'hF1, 8'h07, "R5");
        chk(pad_pu[28] && pad_oe[28] && pad_out[28], "R5", {29'b0, pad_pu[28], pad_oe[28], pad_out[28]}, 32'h7);

        // R6: push-pull pin 3 driving low, open-drain pin 13
        wr(8'hF0, 8'h03); wr(8'hF1, 8'h03);
        settle();
        chk(pad_oe[3] && !pad_out[3], "R6", {30'b0, pad_oe[3], pad_out[3]}, 32'h2);
        wr(8'hF0, 8'h15); wr(8'hF1, 8'h01);
        settle();
        chk(!pad_oe[13] && !pad_out[13], "R6", {30'b0, pad_oe[13], pad_out[13]}, 32'h0);
        wr(8'h04, 8'h1C);
        settle();
        chk(pad_oe[13] && !pad_out[13], "R6", {30'b0, pad_oe[13], pad_out[13]}, 32'h2);

        // R7: enable readback
        wr(8'h06, 8'h5A);
        rd_chk(8'h06, 8'h5A, "R7");

        // R8: enabled edge appears one cycle after data-in
        wr(8'h06, 8'h00); wr(8'h02, 8'h01);
        @(negedge clk) pad_in[0] = 1'b1;
        rd_chk(8'h03, 8'h00, "R8");
        rd_chk(8'h03, 8'h00, "R8");
        rd_chk(8'h03, 8'h01, "R8");

        // R9: write-1 clear, then an edge colliding with a clear
        wr(8'h03, 8'h00);
        rd_chk(8'h03, 8'h01, "R9");
        wr(8'h03, 8'h01);
        rd_chk(8'h03, 8'h00, "R9");
        wr(8'h02, 8'h03);
        @(negedge clk) pad_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h03; bus_wdata = 8'h02;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        rd_chk(8'h03, 8'h02, "R9");

        // R10: unmapped accesses
        wr(8'h0C, 8'hFF); wr(8'hF2, 8'hFF);
        rd_chk(8'h0C, 8'h00, "R10");
        rd_chk(8'hF2, 8'h00, "R10");
        rd_chk(8'h00, 8'hA5, "R10");

        // Mixed traffic against the model
        for (int k = 0; k < 800; k++) begin
            @(negedge clk);
            bus_addr  = ADDRS[$urandom % 16];
            bus_wdata = 8'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            if ((k % 5) == 0) pad_in = NP'($urandom);
        end
        @(negedge clk) bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule